// File: doc/BRIEF.md
# Low-Power Infrared Baud Generator

This block keeps a 16-bit low-power divisor and turns it into the clock enable that an infrared receiver uses to judge minimum pulse width. The divisor is held in two byte registers, one for the low half and one for the high half. Software writes and reads them through a small byte-wide port. The port reaches the divisor only while the divisor-latch access bit is set. When that bit is clear, the port's writes do nothing here, and its reads return the byte from the register that normally shares the address.

A down-counter in the serial clock domain produces a one-cycle tick every `divisor` cycles. This is sixteen times the low-power baud rate, which is the serial clock frequency divided by sixteen times the divisor. The same divisor sets the shortest receive pulse that counts as genuine. A divisor of zero stops the tick and all pulse detection.

Each accepted divisor write starts a settling window of eight serial-clock cycles. The block holds `ready` low during that window and refuses transfer requests until it ends.

Top module: `lp_sir_baudgen`

## Requirements
- R1: While `rst` is sampled high, and afterwards until other stimulus arrives, the outputs are as follows: the divisor is 0, `ready` is 1, and `lp_tick`, `pulse_ok`, `xfer_gnt` and `rdata` are all 0.
- R2: A write with `dlab`=1 stores `wdata` into the low byte when `sel`=0 and into the high byte when `sel`=1. A write with `dlab`=0 leaves both bytes unchanged.
- R3: A read updates `rdata` at the next rising edge. With `dlab`=1 it returns the byte chosen by `sel` (0 low, 1 high). With `dlab`=0 it returns `alt_rdata`. Without a read, `rdata` holds its value.
- R4: After an accepted write, the tick counter restarts. `lp_tick` is high for one cycle after the second rising edge that follows the write, and then every D cycles, where D is the 16-bit divisor ({high,low}) and D is nonzero.
- R5: While the divisor is 0, `lp_tick` and `pulse_ok` stay 0.
- R6: `ready` goes low at the edge that accepts a divisor write. It stays low for exactly 8 cycles and then returns high. A write made inside the window restarts the window.
- R7: `xfer_gnt` is a registered copy of `xfer_req` AND `ready`, so no grant appears while `ready` is low.
- R8: With D nonzero, `pulse_ok` is high for one cycle when `sir_in` has been sampled 1 on D consecutive edges. It fires once per pulse. A pulse sampled high on fewer than D edges yields no `pulse_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| dlab | input | 1 | Divisor-latch access bit from line control |
| wdata | input | 8 | Write data |
| alt_rdata | input | 8 | Data of the register sharing the address when `dlab`=0 |
| rdata | output | 8 | Registered read data |
| xfer_req | input | 1 | Transmit/receive start request |
| xfer_gnt | output | 1 | Request granted (settled) |
| ready | output | 1 | Divisor has settled |
| sir_in | input | 1 | Infrared receive input, active high |
| lp_tick | output | 1 | 16x low-power baud tick |
| pulse_ok | output | 1 | Valid pulse detected |

## Verification
The tick output is exercised with divisors of 1, 3, 4 and 258, all beside the zero case. These values separate an off-by-one in the reload value from a failure to combine the two bytes, and a one-cycle tick stream from a stalled counter. Infrared pulses one cycle shorter than, exactly equal to, and longer than the divisor expose a filter that is too strict, too lax or retriggering. The same pulses sent while the divisor is zero show whether detection is really disabled. Writes and reads are issued with the access bit both set and cleared, and transfer requests are held across the settling window. Together these show whether the access gating, the read path and the eight-cycle block are correct.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int BYTE_W = 8;
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;
endpackage

// File: rtl/lpd_regs.sv
module lpd_regs
  import lpd_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              sel,
  input  logic              dlab,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] alt_rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic              wr_acc,
  output logic [BYTE_W-1:0] rdata
);
  localparam int NBYTES = DIV_W / BYTE_W;

  logic [BYTE_W-1:0] byte_q [NBYTES];

  assign wr_acc = reg_wr && dlab;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        byte_q[b] <= '0;
      else if (wr_acc && (int'(sel) == b))
        byte_q[b] <= wdata;
    end
    assign divisor[b*BYTE_W +: BYTE_W] = byte_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (reg_rd)
      rdata <= dlab ? ((sel == SEL_HI) ? byte_q[NBYTES-1] : byte_q[0]) : alt_rdata;
  end
endmodule

// File: rtl/lpd_settle.sv
module lpd_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_acc,
  input  logic xfer_req,
  output logic ready,
  output logic xfer_gnt
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] left_q;

  assign ready = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      xfer_gnt <= 1'b0;
    end else begin
      xfer_gnt <= xfer_req && ready;
      if (wr_acc)
        left_q <= CW'(SETTLE_CYC);
      else if (!ready)
        left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/lpd_tick_gen.sv
module lpd_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             lp_tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || divisor == '0) begin
      cnt_q   <= '0;
      lp_tick <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= divisor - 1'b1;
      lp_tick <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
      lp_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lpd_pulse_filter.sv
module lpd_pulse_filter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sir_in,
  output logic             pulse_ok
);
  logic [DIV_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || divisor == '0 || !sir_in) begin
      run_q    <= '0;
      pulse_ok <= 1'b0;
    end else begin
      pulse_ok <= (run_q == divisor - 1'b1);
      if (run_q != '1)
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/lp_sir_baudgen.sv
module lp_sir_baudgen
  import lpd_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              sel,
  input  logic              dlab,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] alt_rdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              xfer_req,
  output logic              xfer_gnt,
  output logic              ready,
  input  logic              sir_in,
  output logic              lp_tick,
  output logic              pulse_ok
);
  logic [DIV_W-1:0] divisor;
  logic             wr_acc;

  lpd_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .sel(sel),
    .dlab(dlab), .wdata(wdata), .alt_rdata(alt_rdata),
    .divisor(divisor), .wr_acc(wr_acc), .rdata(rdata)
  );

  lpd_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .xfer_req(xfer_req),
    .ready(ready), .xfer_gnt(xfer_gnt)
  );

  lpd_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .restart(wr_acc), .divisor(divisor), .lp_tick(lp_tick)
  );

  lpd_pulse_filter #(.DIV_W(DIV_W)) filt_i (
    .clk(clk), .rst(rst), .divisor(divisor), .sir_in(sir_in), .pulse_ok(pulse_ok)
  );
endmodule

// File: rtl/lpd_chk.sv
module lpd_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             dlab,
  input logic [DIV_W-1:0] divisor,
  input logic             ready,
  input logic             xfer_gnt,
  input logic             sir_in,
  input logic             lp_tick,
  input logic             pulse_ok
);
  // R2
  no_gated_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !dlab) |=> $stable(divisor));
  // R5
  zero_div_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |=> (!lp_tick && !pulse_ok));
  // R6
  write_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && dlab) |=> !ready);
  // R7
  grant_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_gnt |-> $past(ready));
  // R8
  pulse_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_ok |-> $past(sir_in));
endmodule

bind lp_sir_baudgen lpd_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .dlab(dlab), .divisor(divisor),
  .ready(ready), .xfer_gnt(xfer_gnt), .sir_in(sir_in),
  .lp_tick(lp_tick), .pulse_ok(pulse_ok)
);

// File: tb/lp_sir_baudgen_tb_top.sv
module lp_sir_baudgen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, sel = 0, dlab = 0, xfer_req = 0, sir_in = 0;
  logic [7:0] wdata = 0, alt_rdata = 0, rdata;
  logic xfer_gnt, ready, lp_tick, pulse_ok;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_lo = 0, m_hi = 0, m_settle = 0, m_phase = 0, m_run = 0, m_rd = 0;
  bit m_tick = 0, m_pok = 0, m_gnt = 0;

  always #5 clk = ~clk;

  lp_sir_baudgen dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .sel(sel),
    .dlab(dlab), .wdata(wdata), .alt_rdata(alt_rdata), .rdata(rdata),
    .xfer_req(xfer_req), .xfer_gnt(xfer_gnt), .ready(ready),
    .sir_in(sir_in), .lp_tick(lp_tick), .pulse_ok(pulse_ok)
  );

  function automatic int dval();
    return m_hi * 256 + m_lo;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lo = 0; m_hi = 0; m_settle = 0; m_phase = 0; m_run = 0; m_rd = 0;
      m_tick = 0; m_pok = 0; m_gnt = 0;
    end else begin
      int d;
      bit acc;
      d = dval();
      acc = reg_wr && dlab;
      m_gnt = xfer_req && (m_settle == 0);
      if (reg_rd) m_rd = dlab ? (sel ? m_hi : m_lo) : int'(alt_rdata);
      if (acc || d == 0) begin
        m_phase = 0; m_tick = 0;
      end else begin
        m_tick = (m_phase == 0);
        m_phase = (m_phase == 0) ? d - 1 : m_phase - 1;
      end
      if (d == 0 || !sir_in) begin
        m_run = 0; m_pok = 0;
      end else begin
        m_pok = (m_run == d - 1);
        if (m_run < 65535) m_run++;
      end
      if (acc) m_settle = 8;
      else if (m_settle > 0) m_settle--;
      if (acc) begin
        if (sel) m_hi = int'(wdata); else m_lo = int'(wdata);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(lp_tick == m_tick, "R4/R5 lp_tick", lp_tick, m_tick);
      check(pulse_ok == m_pok, "R8 pulse_ok", pulse_ok, m_pok);
      check(ready == (m_settle == 0), "R6 ready", ready, m_settle == 0);
      check(xfer_gnt == m_gnt, "R7 xfer_gnt", xfer_gnt, m_gnt);
      check(int'(rdata) == m_rd, "R3 rdata", rdata, m_rd);
    end
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(bit s, logic [7:0] d, bit dl);
    @(negedge clk);
    reg_wr = 1; sel = s; wdata = d; dlab = dl;
    @(negedge clk);
    reg_wr = 0; dlab = 0;
  endtask

  task automatic rd(bit s, bit dl, logic [7:0] alt, string req, int exp);
    @(negedge clk);
    reg_rd = 1; sel = s; dlab = dl; alt_rdata = alt;
    @(negedge clk);
    reg_rd = 0; dlab = 0;
    check(int'(rdata) == exp, req, rdata, exp);
  endtask

  task automatic pulse(int w);
    @(negedge clk);
    sir_in = 1;
    idle(w);
    sir_in = 0;
    idle(12);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(lp_tick == 1'b0 && pulse_ok == 1'b0, "R1 tick/pulse", lp_tick, 0);
    check(rdata == 8'h00 && xfer_gnt == 1'b0, "R1 rdata/gnt", rdata, 0);
    rd(0, 1, 8'h00, "R1 low byte", 0);
    rd(1, 1, 8'h00, "R1 high byte", 0);
    // R5 zero divisor: pulses ignored, no ticks
    pulse(6);
    idle(20);
    // R2/R4/R6/R7 divisor 4 with transfers requested across the window
    xfer_req = 1;
    wr(0, 8'd4, 1);
    idle(40);
    xfer_req = 0;
    // R2 gated write ignored, R3 reads
    wr(1, 8'h77, 0);
    rd(1, 1, 8'h00, "R2 high byte unchanged", 0);
    rd(0, 1, 8'h00, "R2 low byte", 4);
    rd(0, 0, 8'h5A, "R3 alt data", 8'h5A);
    // R4 divisor 1 and 3
    wr(0, 8'd1, 1);
    idle(20);
    wr(0, 8'd3, 1);
    idle(30);
    // R6 write inside window restarts it
    xfer_req = 1;
    wr(0, 8'd3, 1);
    idle(3);
    wr(0, 8'd3, 1);
    idle(15);
    xfer_req = 0;
    // R2/R4 both bytes: 0x0102 = 258
    wr(1, 8'd1, 1);
    wr(0, 8'd2, 1);
    rd(1, 1, 8'h00, "R2 high byte", 1);
    idle(800);
    // R8 pulse filter, divisor 5
    wr(1, 8'd0, 1);
    wr(0, 8'd5, 1);
    idle(10);
    pulse(4);
    pulse(5);
    pulse(9);
    pulse(1);
    // R5 back to zero
    wr(0, 8'd0, 1);
    pulse(8);
    idle(30);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule